// File: doc/BRIEF.md
# Block-Based Memory Protection Controller Configuration Registers

This block is the register bank that programs a block-based memory protection controller. A processor reaches it through a simple 32-bit memory-mapped request port. Each request carries an address, write data, an access size and a secure attribute. The bank holds the following state:

- a control register with three live bits;
- a table index and a window onto a table of 32-bit security words, with one bit for each protected memory block;
- an interrupt status bit and an interrupt enable bit, with write-only set and clear strobes;
- a set of fixed identification bytes.

The full table is exported as a flat vector to the access filter that sits in the data path. A level interrupt is raised when the status and enable bits are both set.

Software normally fills the table through the window. It writes the index once and then streams full-word writes, because auto-increment steps the index after each one. Setting the lockdown bit freezes control, the table and the interrupt enable until the next reset. Non-secure masters can reach only the identification bytes. Every other offset reads as zero to them, and their writes there have no effect. Every request gets a response exactly one cycle later, and every response is OK.

Top module: `mpc_cfg_regs`

## Requirements
- R1: The control word keeps only three bits: bit 4 (secure error response), bit 8 (auto-increment) and bit 31 (lockdown). All other bits read as 0 and ignore writes. After reset the control word reads 0x00000100.
- R2: A non-secure request (`req_secure`=0) to any word offset below 0xFD0 reads 0 and changes no state.
- R3: The window at offset 0x1C reads or writes the table word selected by the index at offset 0x18. After a full-word window access with auto-increment set, the index advances by one. It wraps to 0 after the value LUT_WORDS-1. When auto-increment is clear, the index does not move.
- R4: A write to the index register stores the written value modulo LUT_WORDS.
- R5: A write whose value has bit 0 set makes the status 1 when sent to offset 0x34, and makes it 0 when sent to offset 0x24. A value with bit 0 clear leaves the status unchanged. `irq` = status AND enable. Status reads at 0x20, and enable is bit 0 at 0x28. Enable resets to 1 and status resets to 0.
- R6: While lockdown is set, writes to control, the window and the enable register are ignored, and such a window write does not move the index. Lockdown is cleared only by reset.
- R7: `req_size` encodes the access size: 0 is a byte at lane `addr[1:0]`, 1 is a halfword at lane `{addr[1],0}`, and 2 or 3 is a full word. Data is right-aligned on both buses.
  - Sub-word writes to control, index and window merge into the current word.
  - Sub-word writes to any other register are zero-extended before use.
  - A sub-word read returns the addressed lanes.
  - A sub-word window access never advances the index.
- R8: Offset 0x10 reads LUT_WORDS, which is ceil(NUM_BLOCKS/32). Offset 0x14 reads BLOCK_LOG2-5.
- R9: The set and clear registers read 0. The words from 0xFD0 to 0xFFC read, in address order, the bytes 04,00,00,00,60,B8,1B,00,0D,F0,05,B1 in bits 7:0. These words ignore writes and are visible to secure and non-secure requests alike.
- R10: Reset clears every table word, the index and the status bit.
- R11: Unmapped offsets and the two info words (0x2C, 0x30) read 0. Every request produces `rsp_valid` exactly one cycle later, and a write's response data is 0.
- R12: Table word i appears on `lut_flat[32*i+31:32*i]` and changes only through a secure, unlocked window write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the register bank |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 or 3 = word |
| req_secure | input | 1 | Secure attribute of the request |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Response, one cycle after each request |
| rsp_rdata | output | 32 | Right-aligned read data (0 for writes) |
| irq | output | 1 | Level interrupt, status AND enable |
| lut_flat | output | 32*LUT_WORDS | All table words, word i at bits 32i+31:32i |

## Verification
The bound checker enforces several rules on every cycle:
- lockdown is sticky, and a locked bank never lets its table change;
- the index stays below LUT_WORDS;
- a non-secure request below the identification range reads 0 and leaves the table, index and interrupt untouched;
- a response follows each request by exactly one cycle;
- a full-word clear write drops the interrupt.

Some behaviours can only be shown by the bench's scenarios: the modulo store and wrap of the index, the byte-lane merging and zero-extension, the identification byte values, and which registers lockdown freezes while the index stays writable.

// File: rtl/mpc_cfg_pkg.sv
package mpc_cfg_pkg;

    localparam int unsigned REG_ADDR_W = 12;

    localparam logic [REG_ADDR_W-1:0] OFF_CTRL  = 12'h000;
    localparam logic [REG_ADDR_W-1:0] OFF_MAX   = 12'h010;
    localparam logic [REG_ADDR_W-1:0] OFF_CFG   = 12'h014;
    localparam logic [REG_ADDR_W-1:0] OFF_IDX   = 12'h018;
    localparam logic [REG_ADDR_W-1:0] OFF_WIN   = 12'h01C;
    localparam logic [REG_ADDR_W-1:0] OFF_STAT  = 12'h020;
    localparam logic [REG_ADDR_W-1:0] OFF_CLR   = 12'h024;
    localparam logic [REG_ADDR_W-1:0] OFF_EN    = 12'h028;
    localparam logic [REG_ADDR_W-1:0] OFF_INFO1 = 12'h02C;
    localparam logic [REG_ADDR_W-1:0] OFF_INFO2 = 12'h030;
    localparam logic [REG_ADDR_W-1:0] OFF_SET   = 12'h034;
    localparam logic [REG_ADDR_W-1:0] OFF_ID_LO = 12'hFD0;

    localparam int unsigned CTRL_SECRESP_BIT = 4;
    localparam int unsigned CTRL_AUTOINC_BIT = 8;
    localparam int unsigned CTRL_LOCK_BIT    = 31;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_MAX, SEL_CFG, SEL_IDX, SEL_WIN, SEL_STAT,
        SEL_CLR, SEL_EN, SEL_INFO1, SEL_INFO2, SEL_SET, SEL_ID
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e    sel;
        logic        visible;
        logic [1:0]  lane;
        logic        full;
        logic        half;
        logic [3:0]  id_num;
    } dec_t;

    function automatic logic [7:0] id_byte(input logic [3:0] n);
        case (n)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h60;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/mpc_addr_decode.sv
module mpc_addr_decode
    import mpc_cfg_pkg::*;
(
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [1:0]            size,
    input  logic                  secure,
    output dec_t                  dec
);

    logic [REG_ADDR_W-1:0] word_off;

    always_comb begin
        word_off    = {addr[REG_ADDR_W-1:2], 2'b00};
        dec         = '0;
        dec.sel     = SEL_NONE;
        case (word_off)
            OFF_CTRL:  dec.sel = SEL_CTRL;
            OFF_MAX:   dec.sel = SEL_MAX;
            OFF_CFG:   dec.sel = SEL_CFG;
            OFF_IDX:   dec.sel = SEL_IDX;
            OFF_WIN:   dec.sel = SEL_WIN;
            OFF_STAT:  dec.sel = SEL_STAT;
            OFF_CLR:   dec.sel = SEL_CLR;
            OFF_EN:    dec.sel = SEL_EN;
            OFF_INFO1: dec.sel = SEL_INFO1;
            OFF_INFO2: dec.sel = SEL_INFO2;
            OFF_SET:   dec.sel = SEL_SET;
            default:   dec.sel = (word_off >= OFF_ID_LO) ? SEL_ID : SEL_NONE;
        endcase
        dec.id_num  = 4'(addr[REG_ADDR_W-1:2] - OFF_ID_LO[REG_ADDR_W-1:2]);
        dec.visible = secure || (word_off >= OFF_ID_LO);
        case (size)
            2'd0: begin
                dec.lane = addr[1:0];
            end
            2'd1: begin
                dec.lane = {addr[1], 1'b0};
                dec.half = 1'b1;
            end
            default: begin
                dec.full = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mpc_lane_unit.sv
module mpc_lane_unit (
    input  logic [1:0]  lane,
    input  logic        full,
    input  logic        half,
    input  logic [31:0] old_word,
    input  logic [31:0] wdata,
    input  logic [31:0] rd_word,
    output logic [31:0] merged,
    output logic [31:0] rd_out
);

    logic [4:0]  shamt;
    logic [31:0] lane_mask;

    always_comb begin
        shamt     = {lane, 3'b000};
        lane_mask = half ? 32'h0000_FFFF : 32'h0000_00FF;
        if (full) begin
            merged = wdata;
            rd_out = rd_word;
        end else begin
            merged = (old_word & ~(lane_mask << shamt)) |
                     ((wdata & lane_mask) << shamt);
            rd_out = (rd_word >> shamt) & lane_mask;
        end
    end

endmodule

// File: rtl/mpc_lut_bank.sv
module mpc_lut_bank #(
    parameter int unsigned WORDS = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [31:0]         wr_data,
    output logic [WORDS*32-1:0] words
);

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                word_q <= wr_data;
            end
        end
        assign words[32*i +: 32] = word_q;
    end

endmodule

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
    import mpc_cfg_pkg::*;
#(
    parameter  int unsigned BLOCK_LOG2 = 12,
    parameter  int unsigned NUM_BLOCKS = 100,
    localparam int unsigned LUT_WORDS  = (NUM_BLOCKS + 31) / 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [REG_ADDR_W-1:0]   req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_secure,
    input  logic [31:0]             req_wdata,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata,
    output logic                    irq,
    output logic [LUT_WORDS*32-1:0] lut_flat
);

    localparam int unsigned IDX_W     = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;
    localparam logic [31:0] MAX_VALUE = 32'(LUT_WORDS);
    localparam logic [31:0] CFG_VALUE = 32'(BLOCK_LOG2 - 5);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LUT_WORDS - 1);

    typedef struct packed {
        logic             sec_resp;
        logic             autoinc;
        logic             lock;
        logic [IDX_W-1:0] idx;
        logic             stat;
        logic             en;
        logic             rsp_valid;
        logic [31:0]      rdata;
    } state_t;

    localparam state_t RESET_ST = '{
        sec_resp: 1'b0, autoinc: 1'b1, lock: 1'b0, idx: '0,
        stat: 1'b0, en: 1'b1, rsp_valid: 1'b0, rdata: '0
    };

    state_t           st_d, st_q;
    dec_t             dec;
    logic [31:0]      ctrl_word, cur_lut, old_word, rd_word, merged, rd_out;
    logic [IDX_W-1:0] idx_inc;
    logic             lut_we, locked_target;
    logic             ctrl_lock;
    logic [IDX_W-1:0] idx_cur;

    mpc_addr_decode i_decode (
        .addr   (req_addr),
        .size   (req_size),
        .secure (req_secure),
        .dec    (dec)
    );

    mpc_lane_unit i_lanes (
        .lane     (dec.lane),
        .full     (dec.full),
        .half     (dec.half),
        .old_word (old_word),
        .wdata    (req_wdata),
        .rd_word  (rd_word),
        .merged   (merged),
        .rd_out   (rd_out)
    );

    mpc_lut_bank #(.WORDS(LUT_WORDS), .IDX_W(IDX_W)) i_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lut_we),
        .wr_idx  (st_q.idx),
        .wr_data (merged),
        .words   (lut_flat)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_SECRESP_BIT] = st_q.sec_resp;
        ctrl_word[CTRL_AUTOINC_BIT] = st_q.autoinc;
        ctrl_word[CTRL_LOCK_BIT]    = st_q.lock;
        cur_lut  = lut_flat[32*st_q.idx +: 32];
        idx_inc  = (st_q.idx == IDX_LAST) ? '0 : st_q.idx + 1'b1;

        case (dec.sel)
            SEL_CTRL: old_word = ctrl_word;
            SEL_IDX:  old_word = 32'(st_q.idx);
            SEL_WIN:  old_word = cur_lut;
            default:  old_word = '0;
        endcase

        case (dec.sel)
            SEL_CTRL: rd_word = ctrl_word;
            SEL_MAX:  rd_word = MAX_VALUE;
            SEL_CFG:  rd_word = CFG_VALUE;
            SEL_IDX:  rd_word = 32'(st_q.idx);
            SEL_WIN:  rd_word = cur_lut;
            SEL_STAT: rd_word = {31'b0, st_q.stat};
            SEL_EN:   rd_word = {31'b0, st_q.en};
            SEL_ID:   rd_word = {24'b0, id_byte(dec.id_num)};
            default:  rd_word = '0;
        endcase

        locked_target = st_q.lock &&
            (dec.sel == SEL_CTRL || dec.sel == SEL_WIN || dec.sel == SEL_EN);

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rdata     = '0;
        lut_we         = 1'b0;

        if (req_valid && !req_write && dec.visible) begin
            st_d.rdata = rd_out;
            if (dec.sel == SEL_WIN && dec.full && st_q.autoinc) begin
                st_d.idx = idx_inc;
            end
        end

        if (req_valid && req_write && dec.visible && !locked_target) begin
            case (dec.sel)
                SEL_CTRL: begin
                    st_d.sec_resp = merged[CTRL_SECRESP_BIT];
                    st_d.autoinc  = merged[CTRL_AUTOINC_BIT];
                    st_d.lock     = merged[CTRL_LOCK_BIT];
                end
                SEL_IDX: st_d.idx = IDX_W'(merged % MAX_VALUE);
                SEL_WIN: begin
                    lut_we = 1'b1;
                    if (dec.full && st_q.autoinc) begin
                        st_d.idx = idx_inc;
                    end
                end
                SEL_CLR: if (merged[0]) st_d.stat = 1'b0;
                SEL_SET: if (merged[0]) st_d.stat = 1'b1;
                SEL_EN:  st_d.en = merged[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rdata;
    assign irq       = st_q.stat & st_q.en;
    assign ctrl_lock = st_q.lock;
    assign idx_cur   = st_q.idx;

endmodule

// File: rtl/mpc_cfg_regs_chk.sv
module mpc_cfg_regs_chk #(
    parameter  int unsigned LUT_WORDS = 4,
    parameter  int unsigned IDX_W     = 2,
    localparam int unsigned LUT_W     = LUT_WORDS * 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [11:0]      req_addr,
    input logic [1:0]       req_size,
    input logic             req_secure,
    input logic [31:0]      req_wdata,
    input logic             rsp_valid,
    input logic [31:0]      rsp_rdata,
    input logic             irq,
    input logic [LUT_W-1:0] lut_flat,
    input logic             ctrl_lock,
    input logic [IDX_W-1:0] idx_cur
);

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_lock |=> ctrl_lock);

    // R6
    locked_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_lock |=> $stable(lut_flat));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx_cur) < LUT_WORDS);

    // R2
    ns_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_secure && req_addr < 12'hFD0) |=>
            ($stable(lut_flat) && $stable(irq) && $stable(idx_cur)));

    // R2
    ns_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && req_addr < 12'hFD0) |=>
            (rsp_rdata == 32'h0));

    // R11
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_secure && req_size[1] &&
         {req_addr[11:2], 2'b00} == 12'h024 && req_wdata[0]) |=> !irq);

endmodule

bind mpc_cfg_regs mpc_cfg_regs_chk #(.LUT_WORDS(LUT_WORDS), .IDX_W(IDX_W)) i_mpc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_secure (req_secure),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .irq        (irq),
    .lut_flat   (lut_flat),
    .ctrl_lock  (ctrl_lock),
    .idx_cur    (idx_cur)
);

// File: tb/test_mpc_cfg_regs.sv
module test_mpc_cfg_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 100;
    localparam int WORDS      = (NB + 31) / 32;

    localparam logic [11:0] A_CTRL = 12'h000, A_MAX = 12'h010, A_CFG = 12'h014,
                            A_IDX = 12'h018, A_WIN = 12'h01C, A_STAT = 12'h020,
                            A_CLR = 12'h024, A_EN = 12'h028, A_INFO1 = 12'h02C,
                            A_SET = 12'h034;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [11:0]           req_addr = '0;
    logic [1:0]            req_size = '0;
    logic [31:0]           req_wdata = '0;
    logic                  rsp_valid, irq;
    logic [31:0]           rsp_rdata;
    logic [WORDS*32-1:0]   lut_flat;

    int total = 0;
    int bad   = 0;

    typedef struct {
        bit          chk;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpc_cfg_regs #(.BLOCK_LOG2(12), .NUM_BLOCKS(NB)) i_mpc_cfg_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_secure(req_secure),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq(irq), .lut_flat(lut_flat)
    );

    task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                compare(32'd1, 32'd0, "R11 response without request");
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (it.chk) compare(rsp_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                          input bit sec, input logic [31:0] d, input bit chk,
                          input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = a;
        req_size   = sz;
        req_secure = sec;
        req_wdata  = d;
        it.chk = chk;
        it.exp = exp;
        it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        access(1'b1, a, 2'd2, 1'b1, d, 1'b1, 32'h0, "R11 write response data");
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        access(1'b0, a, 2'd2, 1'b1, 32'h0, 1'b1, exp, tag);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        apply_reset();
        // reset state
        rd(A_CTRL, 32'h0000_0100, "R1 control reset value");
        compare({31'b0, irq}, 32'h0, "R10 irq after reset");
        compare(lut_flat[31:0], 32'h0, "R10 table word0 after reset");
        compare(lut_flat[127:96], 32'h0, "R10 table word3 after reset");
        rd(A_IDX, 32'h0, "R10 index after reset");
        rd(A_STAT, 32'h0, "R10 status after reset");
        rd(A_EN, 32'h1, "R5 enable reset value");

        // geometry
        rd(A_MAX, 32'(WORDS), "R8 max index value");
        rd(A_CFG, 32'd7, "R8 block config value");

        // index modulo
        wr(A_IDX, 32'd6);
        rd(A_IDX, 32'd2, "R4 index 6 mod 4");

        // window writes with auto-increment and wrap
        wr(A_WIN, 32'hA5A5_0001);
        wr(A_WIN, 32'h5A5A_0002);
        rd(A_IDX, 32'd0, "R3 index wrapped after two writes");
        compare(lut_flat[95:64], 32'hA5A5_0001, "R12 table word2 position");
        compare(lut_flat[127:96], 32'h5A5A_0002, "R3 table word3 written");

        // window reads advance the index
        rd(A_WIN, 32'h0, "R3 read word0");
        rd(A_WIN, 32'h0, "R3 read word1");
        rd(A_WIN, 32'hA5A5_0001, "R3 read word2");
        rd(A_IDX, 32'd3, "R3 index after three reads");

        // sub-word window write merges, no auto-increment
        access(1'b1, 12'h01D, 2'd0, 1'b1, 32'h0000_00EE, 1'b0, 32'h0, "");
        rd(A_IDX, 32'd3, "R7 byte window write keeps index");
        compare(lut_flat[127:96], 32'h5A5A_EE02, "R7 byte merged into table word");
        access(1'b0, 12'h01E, 2'd1, 1'b1, 32'h0, 1'b1, 32'h0000_5A5A, "R7 halfword read lane 2");
        access(1'b0, 12'h01D, 2'd0, 1'b1, 32'h0, 1'b1, 32'h0000_00EE, "R7 byte read lane 1");
        rd(A_IDX, 32'd3, "R7 sub-word window read keeps index");

        // control merge and masking
        access(1'b1, A_CTRL, 2'd0, 1'b1, 32'h0000_0010, 1'b0, 32'h0, "");
        rd(A_CTRL, 32'h0000_0110, "R7 control byte write merges");
        wr(A_CTRL, 32'h7FFF_FEFF);
        rd(A_CTRL, 32'h0000_0010, "R1 control reserved bits read zero");

        // auto-increment off
        wr(A_WIN, 32'h0000_1234);
        rd(A_IDX, 32'd3, "R3 no advance with auto-increment clear");
        compare(lut_flat[127:96], 32'h0000_1234, "R3 word3 written at index");

        // interrupt
        wr(A_SET, 32'h1);
        compare({31'b0, irq}, 32'h1, "R5 irq after set");
        rd(A_STAT, 32'h1, "R5 status after set");
        wr(A_EN, 32'h0);
        compare({31'b0, irq}, 32'h0, "R5 irq masked by enable");
        wr(A_EN, 32'h1);
        compare({31'b0, irq}, 32'h1, "R5 irq with enable back");
        wr(A_CLR, 32'h1);
        compare({31'b0, irq}, 32'h0, "R5 irq after clear");
        wr(A_SET, 32'h2);
        compare({31'b0, irq}, 32'h0, "R5 set without bit 0 ignored");
        rd(A_SET, 32'h0, "R9 set reads zero");
        rd(A_CLR, 32'h0, "R9 clear reads zero");

        // sub-word zero-extension on enable
        access(1'b1, 12'h029, 2'd0, 1'b1, 32'h0000_0001, 1'b0, 32'h0, "");
        rd(A_EN, 32'h0, "R7 byte write to enable zero-extended");
        wr(A_EN, 32'h1);

        // non-secure filtering
        access(1'b0, A_CTRL, 2'd2, 1'b0, 32'h0, 1'b1, 32'h0, "R2 non-secure control read");
        access(1'b1, A_WIN, 2'd2, 1'b0, 32'h0000_DEAD, 1'b0, 32'h0, "");
        compare(lut_flat[127:96], 32'h0000_1234, "R2 non-secure window write ignored");
        access(1'b1, A_SET, 2'd2, 1'b0, 32'h1, 1'b0, 32'h0, "");
        compare({31'b0, irq}, 32'h0, "R2 non-secure set ignored");
        access(1'b1, A_IDX, 2'd2, 1'b0, 32'h0, 1'b0, 32'h0, "");
        rd(A_IDX, 32'd3, "R2 non-secure index write ignored");
        access(1'b0, 12'hFD0, 2'd2, 1'b0, 32'h0, 1'b1, 32'h04, "R9 id byte 0 non-secure");
        access(1'b0, 12'hFE0, 2'd2, 1'b0, 32'h0, 1'b1, 32'h60, "R9 id byte 4");
        access(1'b0, 12'hFE8, 2'd2, 1'b0, 32'h0, 1'b1, 32'h1B, "R9 id byte 6");
        access(1'b0, 12'hFF0, 2'd2, 1'b0, 32'h0, 1'b1, 32'h0D, "R9 id byte 8");
        access(1'b0, 12'hFFC, 2'd2, 1'b0, 32'h0, 1'b1, 32'hB1, "R9 id byte 11");
        wr(12'hFD0, 32'hFF);
        rd(12'hFD0, 32'h04, "R9 id write ignored");

        // unmapped and info
        rd(12'h040, 32'h0, "R11 unmapped reads zero");
        rd(A_INFO1, 32'h0, "R11 info reads zero");

        // lockdown
        wr(A_CTRL, 32'h8000_0100);
        rd(A_CTRL, 32'h8000_0100, "R6 lockdown set");
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, 32'h8000_0100, "R6 control frozen");
        wr(A_WIN, 32'h0000_9999);
        compare(lut_flat[127:96], 32'h0000_1234, "R6 window write ignored");
        rd(A_IDX, 32'd3, "R6 locked window write keeps index");
        wr(A_EN, 32'h0);
        wr(A_SET, 32'h1);
        compare({31'b0, irq}, 32'h1, "R6 enable frozen");
        wr(A_IDX, 32'd1);
        rd(A_IDX, 32'd1, "R6 index still writable");

        // only reset leaves lockdown
        apply_reset();
        rd(A_CTRL, 32'h0000_0100, "R6 reset clears lockdown");
        compare(lut_flat[127:96], 32'h0, "R10 table cleared by reset");
        compare({31'b0, irq}, 32'h0, "R10 status cleared by reset");

        repeat (2) @(negedge clk);
        compare(32'(exp_q.size()), 32'h0, "R11 every request answered");
        finish_run();
    end

endmodule